// File: doc/BRIEF.md
# Serial Poll Status and Service Request Unit

This unit is the device-side half of an IEEE-488 serial poll. Local firmware writes an 8-bit status byte whose bit 6 is a request flag; while that flag is held, the unit pulls the bus service-request line. Once the controller has enabled serial polling and the device is addressed as talker with ATN released, the unit offers the status byte to an external byte sender. Bit 6 of that byte carries the live state of the request line, and bits 7 and 5..0 carry the last written value.

When the controller accepts the offered byte while a request is pending, the unit drops its request on its own. When the controller then takes ATN back, the unit gives a one-cycle completion pulse. Firmware can raise a new request at any time by writing another byte with bit 6 set. The source handshake and the decoding of the poll-enable and poll-disable commands are outside this unit. They arrive as single-cycle strobes.

Top module: `srq_poll_unit`

## Requirements
- R1: A host write whose data bit 6 is 1 drives `srq_out` high from the next cycle, and it stays high until the request is cleared or overwritten.
- R2: A `byte_accepted` strobe while `tx_valid` is high and a request is pending clears bit 6 of the stored status from the next cycle, so `srq_out` falls.
- R3: `tx_byte` bit 6 equals `srq_out`. Bits 7 and 5..0 equal the same bits of the last host write.
- R4: A poll taken while no request is pending offers the last written byte with bit 6 at 0, and `srq_out` stays low.
- R5: `tx_valid` is high exactly when the poll is active, `talk_addr` is high and `atn` is low.
- R6: `poll_active` rises the cycle after `spe_cmd` and falls the cycle after `spd_cmd`. If both strobes come in one cycle, the poll ends up inactive.
- R7: If a request was granted during the poll, `poll_done` is a one-cycle pulse in the cycle after `atn` is first sampled high following that grant.
- R8: If no request was pending when the byte was accepted, `poll_done` stays low.
- R9: A host write in the same cycle as an automatic clear wins, so the written bit 6 is kept.
- R10: After a clear, a new host write with bit 6 set raises `srq_out` again.
- R11: After reset `srq_out`, `tx_byte`, `poll_active` and `poll_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Status byte write strobe |
| host_wdata | input | 8 | Status byte, bit 6 is the request flag |
| spe_cmd | input | 1 | Serial-poll-enable command strobe |
| spd_cmd | input | 1 | Serial-poll-disable command strobe |
| talk_addr | input | 1 | Device addressed as talker |
| atn | input | 1 | Attention line, 1 = asserted |
| byte_accepted | input | 1 | Controller accepted the offered byte |
| srq_out | output | 1 | Service request drive, 1 = assert |
| tx_byte | output | 8 | Byte offered to the byte sender |
| tx_valid | output | 1 | Byte offered during a poll |
| poll_active | output | 1 | Serial poll in progress |
| poll_done | output | 1 | One-cycle poll-completion pulse |

## Verification
A stored request bit that is wrong shows on `srq_out` and in bit 6 of `tx_byte` in the very next cycle, because both are read straight from it. A grant flag that is lost or stuck shows up only when ATN next rises: `poll_done` is then missing or is raised without cause. The bench therefore closes every poll with an ATN edge. A poll-state error shows at once on `poll_active` and `tx_valid`.

// File: rtl/srq_poll_unit.sv
module srq_poll_unit #(
  parameter int W = 8,
  parameter int RQ = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         spe_cmd,
  input  logic         spd_cmd,
  input  logic         talk_addr,
  input  logic         atn,
  input  logic         byte_accepted,
  output logic         srq_out,
  output logic [W-1:0] tx_byte,
  output logic         tx_valid,
  output logic         poll_active,
  output logic         poll_done
);

  logic [W-1:0] stat_q;
  logic         grant_q, atn_d;
  logic         take;

  assign srq_out  = stat_q[RQ];
  assign tx_valid = poll_active & talk_addr & ~atn;
  assign take     = byte_accepted & tx_valid & srq_out;

  always_comb begin
    tx_byte     = stat_q;
    tx_byte[RQ] = srq_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q      <= '0;
      poll_active <= 1'b0;
      grant_q     <= 1'b0;
      atn_d       <= 1'b0;
      poll_done   <= 1'b0;
    end else begin
      if (host_wr)   stat_q     <= host_wdata;
      else if (take) stat_q[RQ] <= 1'b0;
      if (spd_cmd)      poll_active <= 1'b0;
      else if (spe_cmd) poll_active <= 1'b1;
      poll_done <= atn & ~atn_d & grant_q;
      if ((atn & ~atn_d & grant_q) | spd_cmd) grant_q <= 1'b0;
      else if (take)                          grant_q <= 1'b1;
      atn_d <= atn;
    end
  end

  p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> srq_out == $past(host_wdata[RQ]));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_accepted && tx_valid && srq_out && !host_wr) |=> !srq_out);
  p_spd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spd_cmd |=> !poll_active);
  p_done_atn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |-> $past(atn));
  p_done_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |-> $past(grant_q));

endmodule

// File: tb/tb_srq_poll_unit.sv
module tb_srq_poll_unit;
  logic clk = 0, rst_n = 0;
  logic wr = 0, spe = 0, spd = 0, talk = 0, atn = 1, acc = 0;
  logic [7:0] wdata = 0;
  logic srq, tv, pa, pd;
  logic [7:0] tb;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  srq_poll_unit dut (
    .clk(clk), .rst_n(rst_n), .host_wr(wr), .host_wdata(wdata),
    .spe_cmd(spe), .spd_cmd(spd), .talk_addr(talk), .atn(atn),
    .byte_accepted(acc), .srq_out(srq), .tx_byte(tb), .tx_valid(tv),
    .poll_active(pa), .poll_done(pd));

  int m_stat = 0, m_act = 0, m_grant = 0, m_atnd = 0, m_done = 0;

  always @(posedge clk) begin
    int tvn, tk, dn;
    if (!rst_n) begin
      m_stat = 0; m_act = 0; m_grant = 0; m_atnd = 0; m_done = 0;
    end else begin
      tvn = (m_act != 0) && talk && !atn;
      tk  = acc && tvn && ((m_stat / 64) % 2 == 1);
      dn  = atn && !m_atnd && m_grant;
      if (wr) m_stat = wdata;
      else if (tk) m_stat = m_stat & 8'hBF;
      if (spd) m_act = 0; else if (spe) m_act = 1;
      m_done = dn;
      if (dn || spd) m_grant = 0; else if (tk) m_grant = 1;
      m_atnd = atn;
    end
  end

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(srq == ((m_stat / 64) % 2), "R1 srq_out", srq, (m_stat / 64) % 2);
      chk(tb == m_stat, "R3 tx_byte", tb, m_stat);
      chk(tv == ((m_act != 0) && talk && !atn), "R5 tx_valid", tv, (m_act != 0) && talk && !atn);
      chk(pa == m_act, "R6 poll_active", pa, m_act);
      chk(pd == m_done, "R7 poll_done", pd, m_done);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hw(input logic [7:0] d);
    wr = 1; wdata = d; cyc(1); wr = 0;
  endtask

  task automatic pulse_spe; spe = 1; cyc(1); spe = 0; endtask
  task automatic pulse_spd; spd = 1; cyc(1); spd = 0; endtask
  task automatic pulse_acc; acc = 1; cyc(1); acc = 0; endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk(srq == 0 && tb == 0 && pa == 0 && pd == 0, "R11 reset", {srq, pa, pd}, 0);
    rst_n = 1; cyc(1);
    hw(8'h45);
    chk(srq == 1, "R1 request raised", srq, 1);
    pulse_spe; talk = 1; atn = 0; cyc(1);
    chk(tv == 1 && tb == 8'h45, "R3 byte offered", tb, 8'h45);
    pulse_acc;
    chk(srq == 0 && tb == 8'h05, "R2 auto clear", tb, 8'h05);
    atn = 1; cyc(1);
    chk(pd == 1, "R7 done pulse", pd, 1);
    cyc(1);
    chk(pd == 0, "R7 pulse one cycle", pd, 0);
    pulse_spd; talk = 0; cyc(1);
    hw(8'h8A);
    pulse_spe; talk = 1; atn = 0; cyc(1);
    chk(tb == 8'h8A && srq == 0, "R4 poll without request", tb, 8'h8A);
    pulse_acc; atn = 1; cyc(1);
    chk(pd == 0, "R8 no done without request", pd, 0);
    cyc(1);
    chk(pd == 0, "R8 no done later", pd, 0);
    atn = 0; hw(8'h7F); cyc(1);
    acc = 1; wr = 1; wdata = 8'h40; cyc(1); acc = 0; wr = 0;
    chk(srq == 1 && tb == 8'h40, "R9 write beats clear", tb, 8'h40);
    pulse_acc;
    chk(srq == 0, "R2 clear second request", srq, 0);
    hw(8'hC1);
    chk(srq == 1 && tb == 8'hC1, "R10 new request", tb, 8'hC1);
    atn = 1; cyc(2);
    pulse_spd; talk = 0; cyc(1);
    spe = 1; spd = 1; cyc(1); spe = 0; spd = 0;
    chk(pa == 0, "R6 disable wins", pa, 0);
    pulse_spe;
    chk(pa == 1, "R6 enable", pa, 1);
    talk = 1; atn = 0; cyc(1);
    chk(tv == 1, "R5 valid when talking", tv, 1);
    talk = 0; cyc(1);
    chk(tv == 0, "R5 not valid unaddressed", tv, 0);
    cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule